// File: doc/BRIEF.md
# Round-Robin Interleaved Multiplier

This block keeps a stream of multiplications moving at the full rate of the fast clock while each multiplier lane gets several cycles to finish its work. Operand pairs arrive at most one per fast cycle with a valid flag. A rotating pointer hands each accepted pair to the next of LANES identical lanes. Each lane holds its operands in an input register and loads its product register a fixed LAT cycles later, so the multiply is a multicycle path. A recombining multiplexer walks the lanes in the same rotation and puts one product per cycle back on the output, in arrival order.

The divided lane clocks of a real slow-lane layout are replaced by one-hot capture enables on the single fast clock. Each lane enable fires once every LANES accepted samples. Gaps in the input stream stall the rotation, so distribution and recombination stay in step. At elaboration the block refuses a configuration when LANES is below two, when LANES does not divide the nominal fast-clock rate FAST_KHZ, or when LAT lies outside 1 to LANES-1. The default is five lanes against a 200 MHz nominal clock, which gives 40 MHz per lane.

Top module: `plm_top`

## Requirements
- R1: out_res equals the unsigned product in_a × in_b of the accepted pair, zero-extended to 2·W bits.
- R2: Each accepted sample produces exactly one out_valid pulse, LAT+1 cycles after the clock edge that captured it. With the default LAT = LANES-1, this latency is LANES cycles.
- R3: Accepted samples go to lanes 0, 1, …, LANES-1 in turn and then wrap to 0. Exactly one lane capture enable is active for an accepted sample, and none is active otherwise.
- R4: While in_valid is low, no lane captures and the rotation pointer holds. The values on in_a and in_b are ignored, and the matching output cycle has out_valid low.
- R5: Under continuous input, a result leaves on every cycle. No lane is asked to capture before its previous product has been registered.
- R6: Results leave in the same order as their samples were accepted, including across gaps.
- R7: A synchronous active-high rst drops every in-flight sample and holds out_valid low. After rst, distribution and recombination restart from lane 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; lanes and output run on it |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operand pair is present this cycle |
| in_a | input | W | First operand, unsigned |
| in_b | input | W | Second operand, unsigned |
| out_valid | output | 1 | out_res carries a product this cycle |
| out_res | output | 2·W | Product of the matching pair |

## Verification
The bench builds three copies side by side from one shared stimulus. The first uses five lanes with LAT 4, the stated default. The second uses two lanes with LAT 1 and 6-bit operands, where the rotation wraps on every other sample and the lane turnaround is tightest. The third uses four lanes with LAT 2, where the latency is shorter than the lane count. Together they cover odd and even rotations, a lane count that is not a power of two (so the pointer must wrap before it overflows), and both the shortest and longest allowed multicycle windows. Continuous bursts, random gaps and a reset taken while the pointer sits mid-rotation are applied to all three at once.

// File: rtl/plm_pkg.sv
package plm_pkg;

    localparam int unsigned PLM_DEF_LANES    = 5;
    localparam int unsigned PLM_DEF_FAST_KHZ = 200000;

    // Next index in a rotation of n positions.
    function automatic int unsigned ring_step(input int unsigned idx, input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/plm_phase_gen.sv
module plm_phase_gen #(
    parameter int LANES = 5,
    parameter int IW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    output logic [LANES-1:0] phase_o
);
    typedef struct packed {
        logic [IW-1:0] ptr;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (valid_i)
            s_d.ptr = IW'(plm_pkg::ring_step(32'(s_q.ptr), LANES));
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_phase
        assign phase_o[k] = valid_i && (s_q.ptr == IW'(k));
    end

    // R3: at most one lane enabled, and one exactly when a sample is accepted
    a_r3_one_phase: assert property (@(posedge clk) disable iff (rst)
        $onehot0(phase_o) && (valid_i == (phase_o != '0)));

    // R4: pointer holds through a gap
    a_r4_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(s_q.ptr));

endmodule

// File: rtl/plm_lane.sv
module plm_lane #(
    parameter int W   = 8,
    parameter int LAT = 4,
    parameter int CW  = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cap_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] prod_o,
    output logic           busy_o
);
    typedef struct packed {
        logic [W-1:0]   a;
        logic [W-1:0]   b;
        logic [CW-1:0]  cnt;
        logic [2*W-1:0] prod;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt == CW'(1))
                s_d.prod = {{W{1'b0}}, s_q.a} * {{W{1'b0}}, s_q.b};
        end
        if (cap_i) begin
            s_d.a   = a_i;
            s_d.b   = b_i;
            s_d.cnt = CW'(LAT);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign prod_o = s_q.prod;
    assign busy_o = (s_q.cnt != '0);

    // R5: a lane is never recaptured while its multiply is outstanding
    a_r5_no_overrun: assert property (@(posedge clk) disable iff (rst)
        cap_i |-> !busy_o);

endmodule

// File: rtl/plm_merge.sv
module plm_merge #(
    parameter int LANES = 5,
    parameter int W     = 8,
    parameter int LAT   = 4,
    parameter int IW    = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           issue_i,
    input  logic [2*W-1:0] lane_prod_i [LANES],
    input  logic [LANES-1:0] lane_busy_i,
    output logic           out_valid_o,
    output logic [2*W-1:0] out_res_o
);
    typedef struct packed {
        logic [LAT:0]   pipe;
        logic [IW-1:0]  rptr;
        logic           ovld;
        logic [2*W-1:0] ores;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.pipe = {s_q.pipe[LAT-1:0], issue_i};
        s_d.ovld = s_q.pipe[LAT];
        if (s_q.pipe[LAT]) begin
            s_d.ores = lane_prod_i[s_q.rptr];
            s_d.rptr = IW'(plm_pkg::ring_step(32'(s_q.rptr), LANES));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign out_valid_o = s_q.ovld;
    assign out_res_o   = s_q.ores;

    // R5: the lane picked by the mux has finished its product
    a_r5_result_ready: assert property (@(posedge clk) disable iff (rst)
        s_q.pipe[LAT] |-> !lane_busy_i[s_q.rptr]);

endmodule

// File: rtl/plm_top.sv
module plm_top #(
    parameter int W        = 8,
    parameter int LANES    = int'(plm_pkg::PLM_DEF_LANES),
    parameter int LAT      = LANES - 1,
    parameter int FAST_KHZ = int'(plm_pkg::PLM_DEF_FAST_KHZ)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [W-1:0]   in_a,
    input  logic [W-1:0]   in_b,
    output logic           out_valid,
    output logic [2*W-1:0] out_res
);
    localparam int IW = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int CW = $clog2(LAT + 1);

    if (LANES < 2) begin : g_bad_lanes
        $error("plm_top: LANES must be at least 2");
    end
    if ((FAST_KHZ % LANES) != 0) begin : g_bad_div
        $error("plm_top: LANES must divide FAST_KHZ");
    end
    if (LAT < 1 || LAT > LANES - 1) begin : g_bad_lat
        $error("plm_top: LAT must lie in 1..LANES-1");
    end

    logic [LANES-1:0] phase_w;
    logic [LANES-1:0] busy_w;
    logic [2*W-1:0]   prod_w [LANES];

    plm_phase_gen #(.LANES(LANES), .IW(IW)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .valid_i (in_valid),
        .phase_o (phase_w)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        plm_lane #(.W(W), .LAT(LAT), .CW(CW)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .cap_i  (phase_w[k]),
            .a_i    (in_a),
            .b_i    (in_b),
            .prod_o (prod_w[k]),
            .busy_o (busy_w[k])
        );
    end

    plm_merge #(.LANES(LANES), .W(W), .LAT(LAT), .IW(IW)) u_merge (
        .clk         (clk),
        .rst         (rst),
        .issue_i     (in_valid),
        .lane_prod_i (prod_w),
        .lane_busy_i (busy_w),
        .out_valid_o (out_valid),
        .out_res_o   (out_res)
    );

    // R7: the cycle after reset carries no result
    a_r7_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);

endmodule

// File: tb/sim_plm_top.sv
module sim_plm_top;

    typedef struct {
        logic [15:0] res;
        int          t;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] in_a = '0;
    logic [7:0] in_b = '0;

    logic        ov0, ov1, ov2;
    logic [15:0] r0, r2;
    logic [11:0] r1;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    exp_t sb [3][$];
    int   lat [3] = '{4, 1, 2};

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    plm_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(ov0), .out_res(r0));

    plm_top #(.W(6), .LANES(2), .LAT(1)) u1 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a[5:0]), .in_b(in_b[5:0]),
        .out_valid(ov1), .out_res(r1));

    plm_top #(.W(8), .LANES(4), .LAT(2)) u2 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(ov2), .out_res(r2));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, exp, cyc);
        end
    endtask

    // Driver: one sample (or gap) per cycle, expected products queued for each copy
    task automatic drive(input bit v, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        in_valid = v;
        in_a     = a;
        in_b     = b;
        if (v) begin
            sb[0].push_back('{res: 16'(a) * 16'(b),             t: cyc + lat[0] + 2});
            sb[1].push_back('{res: 16'(a[5:0]) * 16'(b[5:0]),   t: cyc + lat[1] + 2});
            sb[2].push_back('{res: 16'(a) * 16'(b),             t: cyc + lat[2] + 2});
        end
    endtask

    // Monitor: compare each emitted result against the queue head
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int i = 0; i < 3; i++) begin
                logic        v;
                logic [15:0] r;
                v = (i == 0) ? ov0 : (i == 1) ? ov1 : ov2;
                r = (i == 0) ? r0  : (i == 1) ? {4'b0, r1} : r2;
                if (v) begin
                    if (sb[i].size() == 0) begin
                        chk(1'b0, "R4 R7 unexpected out_valid", 1, 0);
                    end else begin
                        exp_t e;
                        e = sb[i].pop_front();
                        chk(r == e.res, "R1 R3 R6 product", int'(r), int'(e.res));
                        chk(cyc == e.t, "R2 latency", cyc, e.t);
                    end
                end else if (sb[i].size() > 0 && sb[i][0].t == cyc) begin
                    chk(1'b0, "R2 R5 missing out_valid", 0, 1);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: outputs quiet during reset
        chk(!ov0 && !ov1 && !ov2, "R7 out_valid in reset", int'(ov0 | ov1 | ov2), 0);
        @(negedge clk);
        rst = 1'b0;
        chk(!ov0 && !ov1 && !ov2, "R7 out_valid after reset", int'(ov0 | ov1 | ov2), 0);

        // R5: continuous burst with corner operands
        drive(1'b1, 8'hFF, 8'hFF);
        drive(1'b1, 8'h00, 8'hAB);
        drive(1'b1, 8'h3F, 8'h3F);
        drive(1'b1, 8'h01, 8'hFF);
        for (int n = 0; n < 40; n++) drive(1'b1, 8'($urandom), 8'($urandom));

        // R4: random gaps; operands keep toggling while invalid
        for (int n = 0; n < 300; n++)
            drive(($urandom % 10) < 6, 8'($urandom), 8'($urandom));

        // R4: long idle with changing operands
        for (int n = 0; n < 10; n++) drive(1'b0, 8'($urandom), 8'($urandom));
        repeat (8) @(negedge clk);
        for (int i = 0; i < 3; i++)
            chk(sb[i].size() == 0, "R2 drained after idle", sb[i].size(), 0);

        // R7: reset with the rotation mid-way and results in flight
        drive(1'b1, 8'd3, 8'd5);
        drive(1'b1, 8'd7, 8'd9);
        drive(1'b1, 8'd11, 8'd13);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        for (int i = 0; i < 3; i++) sb[i].delete();
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(!ov0 && !ov1 && !ov2, "R7 in-flight dropped", int'(ov0 | ov1 | ov2), 0);

        // R6: stream after reset must restart at lane 0 in order
        for (int n = 0; n < 50; n++)
            drive(($urandom % 4) != 0, 8'($urandom), 8'($urandom));
        for (int n = 0; n < 30; n++) drive(1'b1, 8'($urandom), 8'($urandom));
        drive(1'b0, 8'h00, 8'h00);
        repeat (10) @(negedge clk);
        for (int i = 0; i < 3; i++)
            chk(sb[i].size() == 0, "R2 every sample answered", sb[i].size(), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule